// File: doc/BRIEF.md
# Front-Panel Status LED Sequencer

This block turns a handful of status levels and single-cycle event pulses into the on/off enables for two front-panel lamps: an error lamp and a test-mode lamp. The error lamp has three behaviours. A slow blink reports an unsupported terminal rate found at power-up. A latched blink reports that a pattern test ran out of time. A short one-shot flash reports a single CRC or bit error. The test-mode lamp glows while the unit is under test, and it briefly inverts each time a valid management packet arrives from the far end.

All durations are counted in ticks of an internal millisecond strobe. The strobe comes from a parameterised clock divider, so a simulation can shrink every period by lowering the cycles-per-millisecond parameter. Event detection, lamp drive electronics and configuration are handled elsewhere.

Top module: `led_sequencer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both `err_led` and `tm_led` are 0.
- R2: A `crc_err` pulse while `test_active` is 0, or a `bit_err` pulse while `test_active` is 1, lights `err_led` from the next cycle. The lamp then stays lit for ERR_FLASH_MS strobe periods: with P clocks per strobe it is still lit (ERR_FLASH_MS-1)*P cycles after the pulse edge and is dark ERR_FLASH_MS*P cycles after it. `crc_err` while `test_active` is 1 and `bit_err` while it is 0 have no effect.
- R3: A qualifying error pulse that arrives during a flash restarts the full flash length from that pulse.
- R4: If `rate_bad` is 1 in the cycle in which `pwrup_done` is first seen high after reset, the error lamp blinks. It starts lit and toggles every RATE_HALF_MS strobe periods until the next reset. A `rate_bad` that rises after that cycle has no effect.
- R5: A `test_timeout` pulse while `test_sw` is 1 latches a blink on the error lamp. The blink starts lit and toggles every TO_HALF_MS strobe periods. Whenever `test_sw` is 0, the latch is clear from the next cycle.
- R6: The error lamp follows the rate-fault blink first, then the timeout blink, then the one-shot flash. While a blink is active, the blink's dark phase shows even when a flash is pending.
- R7: With no packet flash running, `tm_led` equals `test_active` in the same cycle.
- R8: A `remote_pkt` pulse makes `tm_led` the inverse of `test_active` from the next cycle for PKT_FLASH_MS strobe periods: still inverted (PKT_FLASH_MS-1)*P cycles after the pulse edge and back to steady PKT_FLASH_MS*P cycles after it. A new pulse restarts the period.
- R9: The strobe fires once every CLK_PER_MS clocks, and every lamp duration is a whole number of strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwrup_done | input | 1 | Level, high once power-up completes |
| rate_bad | input | 1 | Level, configured terminal rate unsupported |
| crc_err | input | 1 | One-cycle CRC error pulse |
| bit_err | input | 1 | One-cycle pattern bit error pulse |
| test_timeout | input | 1 | One-cycle pattern test timeout pulse |
| test_active | input | 1 | Level, unit is in test mode |
| test_sw | input | 1 | Level, pattern test switch on |
| remote_pkt | input | 1 | One-cycle valid remote packet pulse |
| err_led | output | 1 | Error lamp enable |
| tm_led | output | 1 | Test-mode lamp enable |

## Verification
The assertions assume that every event input is a clean synchronous pulse and that `pwrup_done` only rises, staying high until the next reset. The bench therefore drives every input on the falling clock edge. It raises each event for exactly one cycle, and it raises power-up once per reset with `rate_bad` already settled. Between table rows the stimulus also waits longer than the longest flash, so each row starts from dark lamps and the expected values do not depend on earlier rows.

// File: rtl/led_sequencer.sv
module led_sequencer #(
  parameter int CLK_PER_MS   = 50000,
  parameter int RATE_HALF_MS = 100,
  parameter int TO_HALF_MS   = 250,
  parameter int ERR_FLASH_MS = 100,
  parameter int PKT_FLASH_MS = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwrup_done,
  input  logic rate_bad,
  input  logic crc_err,
  input  logic bit_err,
  input  logic test_timeout,
  input  logic test_active,
  input  logic test_sw,
  input  logic remote_pkt,
  output logic err_led,
  output logic tm_led
);
  localparam int TW = $clog2(CLK_PER_MS + 1);
  localparam int RW = $clog2(RATE_HALF_MS + 1);
  localparam int OW = $clog2(TO_HALF_MS + 1);
  localparam int FW = $clog2(ERR_FLASH_MS + 1);
  localparam int PW = $clog2(PKT_FLASH_MS + 1);

  logic [TW-1:0] tcnt;
  logic          tick;
  logic          pwr_seen, rate_fault, rate_ph;
  logic [RW-1:0] rate_cnt;
  logic          to_blink, to_ph;
  logic [OW-1:0] to_cnt;
  logic [FW-1:0] flash_cnt;
  logic [PW-1:0] pkt_cnt;
  logic          err_evt;

  assign tick    = (tcnt == TW'(CLK_PER_MS - 1));
  assign err_evt = test_active ? bit_err : crc_err;

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_seen   <= 1'b0;
      rate_fault <= 1'b0;
    end else begin
      if (pwrup_done) pwr_seen <= 1'b1;
      if (pwrup_done && !pwr_seen && rate_bad) rate_fault <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rate_fault) begin
      rate_cnt <= '0;
      rate_ph  <= 1'b1;
    end else if (tick) begin
      if (rate_cnt == RW'(RATE_HALF_MS - 1)) begin
        rate_cnt <= '0;
        rate_ph  <= ~rate_ph;
      end else begin
        rate_cnt <= rate_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !test_sw) to_blink <= 1'b0;
    else if (test_timeout)  to_blink <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !to_blink) begin
      to_cnt <= '0;
      to_ph  <= 1'b1;
    end else if (tick) begin
      if (to_cnt == OW'(TO_HALF_MS - 1)) begin
        to_cnt <= '0;
        to_ph  <= ~to_ph;
      end else begin
        to_cnt <= to_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                      flash_cnt <= '0;
    else if (err_evt)                flash_cnt <= FW'(ERR_FLASH_MS);
    else if (tick && flash_cnt != 0) flash_cnt <= flash_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                    pkt_cnt <= '0;
    else if (remote_pkt)           pkt_cnt <= PW'(PKT_FLASH_MS);
    else if (tick && pkt_cnt != 0) pkt_cnt <= pkt_cnt - 1'b1;
  end

  assign err_led = rst_n && (rate_fault ? rate_ph : to_blink ? to_ph : (flash_cnt != 0));
  assign tm_led  = rst_n && (test_active ^ (pkt_cnt != 0));

  a_r2_flash_lights: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt && pwr_seen && !rate_fault && !to_blink && !test_timeout) |=> err_led);
  a_r4_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rate_fault |=> rate_fault);
  a_r4_fault_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rate_fault) |-> $past(rate_bad && pwrup_done && !pwr_seen));
  a_r5_switch_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !test_sw |=> !to_blink);
  a_r8_pkt_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    remote_pkt |=> (tm_led != test_active));
endmodule

// File: tb/tb_led_sequencer.sv
module tb_led_sequencer;
  localparam int P = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic pwrup_done = 1'b0, rate_bad = 1'b0, crc_err = 1'b0, bit_err = 1'b0;
  logic test_timeout = 1'b0, test_active = 1'b0, test_sw = 1'b0, remote_pkt = 1'b0;
  logic err_led, tm_led;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  led_sequencer #(.CLK_PER_MS(P), .RATE_HALF_MS(3), .TO_HALF_MS(2),
                  .ERR_FLASH_MS(10), .PKT_FLASH_MS(8)) dut (
    .clk(clk), .rst_n(rst_n), .pwrup_done(pwrup_done), .rate_bad(rate_bad),
    .crc_err(crc_err), .bit_err(bit_err), .test_timeout(test_timeout),
    .test_active(test_active), .test_sw(test_sw), .remote_pkt(remote_pkt),
    .err_led(err_led), .tm_led(tm_led));

  // {test_active, crc, bit, pkt, wait[7:0], exp_err, exp_tm}
  localparam logic [13:0] VEC [12] = '{
    {4'b0100, 8'd1,  2'b10}, {4'b0100, 8'd36, 2'b10}, {4'b0100, 8'd40, 2'b00},
    {4'b0010, 8'd1,  2'b00}, {4'b1100, 8'd1,  2'b01}, {4'b1010, 8'd1,  2'b11},
    {4'b1001, 8'd1,  2'b00}, {4'b1001, 8'd28, 2'b00}, {4'b1001, 8'd32, 2'b01},
    {4'b0001, 8'd1,  2'b01}, {4'b0001, 8'd28, 2'b01}, {4'b0001, 8'd32, 2'b00}};

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input logic pw, input logic rb);
    @(negedge clk);
    rst_n = 1'b0; pwrup_done = pw; rate_bad = rb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk) sig = 1'b1;
    @(negedge clk) sig = 1'b0;
  endtask

  function automatic void bump(input logic prev, input logic cur, ref int rises, ref int lows);
    if (cur && !prev) rises++;
    if (!cur) lows++;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int rises, lows;
    logic prev;
    // R1 reset state
    pwrup_done = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 err in reset", err_led, 1'b0);
    chk("R1 tm in reset", tm_led, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 err after reset", err_led, 1'b0);
    chk("R1 tm after reset", tm_led, 1'b0);

    // table: R2, R7, R8, R9 timing
    for (int i = 0; i < 12; i++) begin
      test_active = VEC[i][13];
      repeat (48) @(negedge clk);
      crc_err = VEC[i][12]; bit_err = VEC[i][11]; remote_pkt = VEC[i][10];
      @(negedge clk);
      crc_err = 1'b0; bit_err = 1'b0; remote_pkt = 1'b0;
      repeat (int'(VEC[i][9:2])) @(negedge clk);
      chk($sformatf("R2/R9 err row %0d", i), err_led, VEC[i][1]);
      chk($sformatf("R7/R8 tm row %0d", i), tm_led, VEC[i][0]);
    end

    // R3 restart of the flash
    test_active = 1'b0;
    repeat (48) @(negedge clk);
    pulse(crc_err);
    repeat (11) @(negedge clk);
    pulse(crc_err);
    repeat (35) @(negedge clk);
    chk("R3 still lit after restart", err_led, 1'b1);
    repeat (5) @(negedge clk);
    chk("R3 dark after restarted flash", err_led, 1'b0);

    // R8 restart of the packet flash
    pulse(remote_pkt);
    repeat (15) @(negedge clk);
    pulse(remote_pkt);
    repeat (27) @(negedge clk);
    chk("R8 inverted after restart", tm_led, 1'b1);
    repeat (5) @(negedge clk);
    chk("R8 steady after restart", tm_led, 1'b0);

    // R5 timeout blink
    test_sw = 1'b1;
    pulse(test_timeout);
    chk("R5 blink starts lit", err_led, 1'b1);
    rises = 0; lows = 0; prev = err_led;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk); bump(prev, err_led, rises, lows); prev = err_led;
    end
    chk("R5 blink rate", (rises >= 3 && rises <= 5), 1'b1);
    // R6 timeout over flash
    pulse(crc_err);
    rises = 0; lows = 0; prev = err_led;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk); bump(prev, err_led, rises, lows); prev = err_led;
    end
    chk("R6 timeout blink dark phase over flash", (lows > 0), 1'b1);
    repeat (48) @(negedge clk);
    test_sw = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R5 cleared by switch", err_led, 1'b0);
    rises = 0; lows = 0; prev = err_led;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); bump(prev, err_led, rises, lows); prev = err_led;
    end
    chk("R5 stays dark", rises, 1'b0);
    // R5 timeout ignored with switch off
    pulse(test_timeout);
    chk("R5 timeout ignored switch off", err_led, 1'b0);

    // R4 power-up rate fault
    do_reset(1'b0, 1'b1);
    @(negedge clk) pwrup_done = 1'b1;
    @(negedge clk);
    chk("R4 fault blink starts lit", err_led, 1'b1);
    rises = 0; lows = 0; prev = err_led;
    for (int k = 0; k < 96; k++) begin
      @(negedge clk); bump(prev, err_led, rises, lows); prev = err_led;
    end
    chk("R4 fault blink rate", (rises >= 3 && rises <= 5), 1'b1);
    // R6 rate fault over flash and timeout
    test_sw = 1'b1;
    test_timeout = 1'b1; crc_err = 1'b1;
    @(negedge clk);
    test_timeout = 1'b0; crc_err = 1'b0;
    rises = 0; lows = 0; prev = err_led;
    for (int k = 0; k < 96; k++) begin
      @(negedge clk); bump(prev, err_led, rises, lows); prev = err_led;
    end
    chk("R6 rate blink over others", (rises >= 3 && rises <= 5), 1'b1);
    test_sw = 1'b0;

    // R4 late rate_bad ignored
    do_reset(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    rate_bad = 1'b1;
    rises = 0; lows = 0; prev = err_led;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); bump(prev, err_led, rises, lows); prev = err_led;
    end
    chk("R4 late rate_bad ignored", (lows == 60), 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule